// File: doc/BRIEF.md
# Masked Interrupt Status Register Bank

This block gathers single-cycle event pulses into a bank of sticky status flags. The flags are grouped into byte-wide registers, and each flag has its own enable bit in a matching mask register. A single registered interrupt line is high while any enabled flag is set. Software services the interrupt by reading status registers over a simple register port. A status read returns the flags and clears that register only. Software therefore needs to read only the registers where it has enabled bits.

An event that arrives in the same clock cycle as the read of its register wins over the clear, so no event is lost. Mask registers are read/write. Status registers are read-only, and a write to a status address is dropped.

Address map: bit 2 of the address picks the space (0 = status, 1 = mask) and bits 1:0 pick the register index. Event input bit `8*k+j` belongs to bit `j` of register `k`.

Top module: `irq_status_bank`

## Requirements
- R1: A pulse on event input bit 8*k+j sets flag j of status register k at the next clock edge, and the flag stays set until a clearing read of register k.
- R2: The interrupt is driven only by flags whose mask bit is 1. A set flag with a 0 mask bit never raises irq_o.
- R3: A read request (req_i=1, we_i=0) to status address k (addr_i[2]=0) clears the flags of register k at that clock edge and leaves every other register unchanged.
- R4: If an event pulse for a flag arrives in the same cycle as a read of its register, that flag is set after the edge, not cleared.
- R5: irq_o is registered. In each cycle it equals the OR over all bits of (flag AND mask) as held in the previous cycle.
- R6: The read data of a request appears on rdata_o in the cycle after the request and holds the value from before any clear. rdata_o holds its value when there is no read.
- R7: A write (req_i=1, we_i=1) to mask address k (addr_i[2]=1) loads mask k at that edge. A write to a status address changes no state.
- R8: Reset sets all flags, all masks, irq_o and rdata_o to 0.
- R9: irq_o returns to 0 once every register that holds an enabled, set flag has been read. Registers with no enabled bits may keep set flags without being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Event pulses, one per flag |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Bit 2 selects the space (0 = status, 1 = mask); bits 1:0 select the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default four registers of eight bits each. This lets a behavioural model follow all 32 flags, the four mask registers and the full three-bit address space, including writes to status addresses. Random sparse events are mixed with random reads and writes, so read/event collisions and partially masked registers occur often. These cases are compared cycle by cycle against the model. Directed sequences cover the cases where a clear might be lost or might reach a neighbouring register.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic {
    SPACE_STATUS = 1'b0,
    SPACE_MASK   = 1'b1
  } space_e;
endpackage

// File: rtl/irq_status_slice.sv
module irq_status_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] flags_q, mask_q;

  // event wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (rd_clr_i ? '0 : flags_q) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign pend_o  = |(flags_q & mask_q);

  // R1
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((flags_q & $past(flags_q | evt_i)) == $past(flags_q | evt_i)));
  // R4
  evt_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> (flags_q == $past(evt_i)));
  // R7
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));
endmodule

// File: rtl/irq_pend_reduce.sv
module irq_pend_reduce #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_i;
  end

  assign irq_o = irq_q;

  // R5
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(pend_i) != '0);
  // R9
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(pend_i) == '0);
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic                sel_mask_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [N-1:0][W-1:0] flags_i,
  input  logic [N-1:0][W-1:0] masks_i,
  output logic [W-1:0]        rdata_o
);
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel_mask_i ? masks_i[idx_i] : flags_i[idx_i];
  end

  assign rdata_o = rdata_q;

  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 4,
  parameter  int unsigned REG_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W   = IDX_W + 1,
  localparam int unsigned EVT_W    = NUM_REGS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  space_e                          space;
  logic [IDX_W-1:0]                idx;
  logic                            rd, wr;
  logic [NUM_REGS-1:0][REG_W-1:0]  flags, masks;
  logic [NUM_REGS-1:0]             pend;

  assign space = space_e'(addr_i[IDX_W]);
  assign idx   = addr_i[IDX_W-1:0];
  assign rd    = req_i && !we_i;
  assign wr    = req_i && we_i;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic clr, mwe;
    assign clr = rd && (space == SPACE_STATUS) && (idx == IDX_W'(k));
    // status space is read-only: writes there decode to nothing
    assign mwe = wr && (space == SPACE_MASK) && (idx == IDX_W'(k));

    irq_status_slice #(.W(REG_W)) u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .evt_i        (evt_i[k*REG_W +: REG_W]),
      .rd_clr_i     (clr),
      .mask_we_i    (mwe),
      .mask_wdata_i (wdata_i),
      .flags_o      (flags[k]),
      .mask_o       (masks[k]),
      .pend_o       (pend[k])
    );
  end

  irq_pend_reduce #(.N(NUM_REGS)) u_reduce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .irq_o  (irq_o)
  );

  irq_read_port #(.N(NUM_REGS), .W(REG_W), .IDX_W(IDX_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd),
    .sel_mask_i (space == SPACE_MASK),
    .idx_i      (idx),
    .flags_i    (flags),
    .masks_i    (masks),
    .rdata_o    (rdata_o)
  );

  // R6
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && space == SPACE_STATUS) |=> (rdata_o == $past(flags[idx])));
  // R3
  other_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && space == SPACE_STATUS && idx != '0) |=>
      ((flags[0] & $past(flags[0])) == $past(flags[0])));
  // R7
  status_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && space == SPACE_STATUS) |=> $stable(masks));
  // R2
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |=> !irq_o);
endmodule

// File: tb/sim_irq_status_bank.sv
module sim_irq_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0] m_flag [4];
  logic [7:0] m_mask [4];
  logic       m_irq;
  logic [7:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin m_flag[k] <= 0; m_mask[k] <= 0; end
      m_irq <= 0; m_rdata <= 0;
    end else begin
      logic any;
      any = 0;
      for (int k = 0; k < 4; k++) any = any | (|(m_flag[k] & m_mask[k]));
      m_irq <= any;
      if (req && !we) m_rdata <= addr[2] ? m_mask[addr[1:0]] : m_flag[addr[1:0]];
      for (int k = 0; k < 4; k++) begin
        logic clr;
        clr = req && !we && !addr[2] && (addr[1:0] == 2'(k));
        m_flag[k] <= (clr ? 8'h00 : m_flag[k]) | evt[k*8 +: 8];
      end
      if (req && we && addr[2]) m_mask[addr[1:0]] <= wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic op(logic r, logic w, logic [2:0] a, logic [7:0] d, logic [31:0] e);
    req = r; we = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0; evt = '0;
    chk("R5 irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R6 rdata", {24'b0, rdata}, {24'b0, m_rdata});
  endtask

  task automatic idle(); op(0, 0, 3'd0, 8'h00, 32'h0); endtask
  task automatic rd_stat(int k); op(1, 0, {1'b0, 2'(k)}, 8'h00, 32'h0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    chk("R8 irq", {31'b0, irq}, 32'h0);
    chk("R8 rdata", {24'b0, rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    op(1, 0, 3'b100, 8'h00, 32'h0);
    chk("R8 mask0", {24'b0, rdata}, 32'h0);

    // R1 sticky set
    op(0, 0, 3'd0, 8'h00, 32'h0000_0800);
    idle(); idle();
    rd_stat(1);
    chk("R1 flag", {24'b0, rdata}, 32'h08);

    // R3 per-register clear
    op(0, 0, 3'd0, 8'h00, 32'h0000_0201);
    rd_stat(0);
    chk("R3 read0", {24'b0, rdata}, 32'h01);
    rd_stat(1);
    chk("R3 reg1 kept", {24'b0, rdata}, 32'h02);
    rd_stat(0);
    chk("R3 reg0 clr", {24'b0, rdata}, 32'h00);

    // R4 event during read wins
    op(0, 0, 3'd0, 8'h00, 32'h0002_0000);
    op(1, 0, 3'b010, 8'h00, 32'h0001_0000);
    chk("R4 pre", {24'b0, rdata}, 32'h02);
    rd_stat(2);
    chk("R4 kept", {24'b0, rdata}, 32'h01);

    // R7 status write ignored, mask write loads
    op(0, 0, 3'd0, 8'h00, 32'h0000_0004);
    op(1, 1, 3'b000, 8'hff, 32'h0);
    rd_stat(0);
    chk("R7 status ro", {24'b0, rdata}, 32'h04);
    op(1, 1, 3'b111, 8'h80, 32'h0);
    op(1, 0, 3'b111, 8'h00, 32'h0);
    chk("R7 mask3", {24'b0, rdata}, 32'h80);

    // R2 masked flag quiet, enabled flag raises
    op(0, 0, 3'd0, 8'h00, 32'h0100_0000);
    idle(); idle();
    chk("R2 masked", {31'b0, irq}, 32'h0);
    op(0, 0, 3'd0, 8'h00, 32'h8000_0000);
    idle(); idle();
    chk("R2 enabled", {31'b0, irq}, 32'h1);

    // R9 only enabled registers need a read
    op(0, 0, 3'd0, 8'h00, 32'h0000_0100);
    rd_stat(3);
    idle(); idle();
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    rd_stat(1);
    chk("R9 reg1 set", {24'b0, rdata}, 32'h01);

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] e;
      e = $urandom() & $urandom() & $urandom();
      op(($urandom() % 3) != 0, ($urandom() % 4) == 0, 3'($urandom()),
         8'($urandom()), e);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule